// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a shift register of the most recent branch outcomes from every branch in the program. That history, not the branch address, selects one entry from a table of two-bit saturating counters. The upper bit of the selected counter is the guess. Branches that run one after another therefore see each other's outcomes in the index, so patterns that repeat across branches can be learned.

The fetch side reads the current history index and the guess directly from the outputs. It keeps the index with the branch. When the branch resolves, the pipeline returns that same index with the real outcome on the update port. The update trains the counter that made the guess. The outcome is also shifted into the history.

The history length is a parameter. The table has one entry for every possible history value.

Top module: `ghist_predictor`

## Requirements
- R1: After reset the history is all zeros, so `pred_idx_o` = 0. Every counter starts at 2'b10 (weakly taken), so `pred_taken_o` = 1.
- R2: `pred_taken_o` is 1 when the counter selected by the current history holds 2'b10 or 2'b11. It is 0 when that counter holds 2'b00 or 2'b01.
- R3: An update with `upd_taken_i` = 1 raises the addressed counter by one step. A counter already at 2'b11 stays at 2'b11.
- R4: An update with `upd_taken_i` = 0 lowers the addressed counter by one step. A counter already at 2'b00 stays at 2'b00.
- R5: Each valid update shifts the history left by one place and drops the oldest outcome. The new outcome enters at bit 0, with 1 meaning taken. For example, 0000 followed by a taken update becomes 0001.
- R6: When `upd_valid_i` = 0, neither the history nor any counter changes, whatever `upd_idx_i` and `upd_taken_i` carry.
- R7: The counter trained is the one named by `upd_idx_i`, even when that differs from the current history.
- R8: If an update writes the entry the current history selects, the guess in that cycle shows the counter value from before the update. The new value appears from the next cycle on.
- R9: An update changes only the addressed counter. All other entries keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_idx_i | input | HIST_W | Table index that was used for this branch's guess |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| pred_idx_o | output | HIST_W | Current global history, which is the table index for the next guess |
| pred_taken_o | output | 1 | Direction guess, 1 = taken |

## Verification
The bench builds the block with its default 4-bit history, which gives a 16-entry table. With only four outcomes in the history, a short run of updates can steer the index onto any chosen entry. This makes saturation at both ends, same-entry read-before-write and training of an entry other than the current one each reachable within a few cycles. A long stretch of random updates with random strobes then compares every cycle's index and guess against a reference model kept in the bench.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b10;
    localparam ctr_t CTR_MAX   = 2'b11;
    localparam ctr_t CTR_MIN   = 2'b00;

    // Saturating step of a two-bit direction counter
    function automatic ctr_t ctr_step(ctr_t cur, logic taken);
        ctr_t nxt;
        if (taken) begin
            nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
        end else begin
            nxt = (cur == CTR_MIN) ? cur : cur - 2'd1;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/ghp_history.sv
module ghp_history #(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist_o
);

    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.hist = {st_q.hist[HIST_W-2:0], outcome};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_o = st_q.hist;

endmodule

// File: rtl/ghp_counter.sv
module ghp_counter
    import ghp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic train_en,
    input  logic taken,
    output ctr_t ctr_o
);

    typedef struct packed {
        ctr_t ctr;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (train_en) begin
            st_d.ctr = ctr_step(st_q.ctr, taken);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctr <= CTR_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctr_o = st_q.ctr;

endmodule

// File: rtl/ghp_table.sv
module ghp_table
    import ghp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [HIST_W-1:0]         wr_idx,
    input  logic                      wr_taken,
    input  logic [HIST_W-1:0]         rd_idx,
    output ctr_t                      rd_ctr,
    output logic [2*(1<<HIST_W)-1:0]  ctr_flat
);

    localparam int ENTRIES = 1 << HIST_W;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == HIST_W'(e));

        ghp_counter u_ctr (
            .clk      (clk),
            .rst_n    (rst_n),
            .train_en (hit),
            .taken    (wr_taken),
            .ctr_o    (ctr_flat[2*e +: 2])
        );
    end

    // Read sees registered state only: the old value when written this cycle
    assign rd_ctr = ctr_flat[{rd_idx, 1'b0} +: 2];

endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor
    import ghp_pkg::*;
#(
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid_i,
    input  logic [HIST_W-1:0] upd_idx_i,
    input  logic              upd_taken_i,
    output logic [HIST_W-1:0] pred_idx_o,
    output logic              pred_taken_o
);

    localparam int ENTRIES = 1 << HIST_W;

    logic [HIST_W-1:0]    hist;
    ctr_t                 sel_ctr;
    logic [2*ENTRIES-1:0] ctr_flat;

    ghp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (upd_valid_i),
        .outcome  (upd_taken_i),
        .hist_o   (hist)
    );

    ghp_table #(.HIST_W(HIST_W)) u_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (upd_valid_i),
        .wr_idx   (upd_idx_i),
        .wr_taken (upd_taken_i),
        .rd_idx   (hist),
        .rd_ctr   (sel_ctr),
        .ctr_flat (ctr_flat)
    );

    assign pred_idx_o   = hist;
    assign pred_taken_o = sel_ctr[1];

endmodule

// File: rtl/ghist_predictor_chk.sv
module ghist_predictor_chk #(
    parameter int HIST_W = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      upd_valid_i,
    input logic [HIST_W-1:0]         upd_idx_i,
    input logic                      upd_taken_i,
    input logic [HIST_W-1:0]         pred_idx_o,
    input logic                      pred_taken_o,
    input logic [2*(1<<HIST_W)-1:0]  ctr_flat
);

    logic [1:0] ctr_at_upd;
    assign ctr_at_upd = ctr_flat[{upd_idx_i, 1'b0} +: 2];

    // R1: a cycle held in reset leaves zero history and a taken guess
    p_reset_state_r1: assert property (@(posedge clk)
        !rst_n |=> (pred_idx_o == '0 && pred_taken_o));

    // R3: saturation at the top
    p_sat_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && upd_taken_i && ctr_at_upd == 2'b11)
        |=> ctr_flat[{$past(upd_idx_i), 1'b0} +: 2] == 2'b11);

    // R4: saturation at the bottom
    p_sat_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid_i && !upd_taken_i && ctr_at_upd == 2'b00)
        |=> ctr_flat[{$past(upd_idx_i), 1'b0} +: 2] == 2'b00);

    // R5: history shifts the outcome in at bit 0
    p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd_valid_i |=> pred_idx_o == {$past(pred_idx_o[HIST_W-2:0]), $past(upd_taken_i)});

    // R6: no strobe, no change
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !upd_valid_i |=> ($stable(pred_idx_o) && $stable(ctr_flat)));

endmodule

bind ghist_predictor ghist_predictor_chk #(.HIST_W(HIST_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .upd_valid_i  (upd_valid_i),
    .upd_idx_i    (upd_idx_i),
    .upd_taken_i  (upd_taken_i),
    .pred_idx_o   (pred_idx_o),
    .pred_taken_o (pred_taken_o),
    .ctr_flat     (ctr_flat)
);

// File: tb/ghist_predictor_tb.sv
`timescale 1ns/1ps
module ghist_predictor_tb;

    localparam int W = 4;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         upd_valid = 1'b0;
    logic [W-1:0] upd_idx = '0;
    logic         upd_taken = 1'b0;
    logic [W-1:0] pred_idx;
    logic         pred_taken;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic [1:0]   m_ctr [N];
    logic [W-1:0] m_ghr;

    int           q_due [$];
    logic [W-1:0] q_idx [$];
    logic         q_tk  [$];
    string        q_tag [$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ghist_predictor #(.HIST_W(W)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .upd_valid_i  (upd_valid),
        .upd_idx_i    (upd_idx),
        .upd_taken_i  (upd_taken),
        .pred_idx_o   (pred_idx),
        .pred_taken_o (pred_taken)
    );

    function automatic logic [1:0] m_step(logic [1:0] c, logic t);
        if (t) return (c == 2'b11) ? c : c + 2'd1;
        return (c == 2'b00) ? c : c - 2'd1;
    endfunction

    // Monitor: pops expectations that have come due and compares them
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] <= cyc) begin
            checks++;
            if (pred_idx !== q_idx[0] || pred_taken !== q_tk[0]) begin
                fails++;
                $display("FAIL %s idx act=%0h exp=%0h taken act=%0b exp=%0b",
                         q_tag[0], pred_idx, q_idx[0], pred_taken, q_tk[0]);
            end
            void'(q_due.pop_front());
            void'(q_idx.pop_front());
            void'(q_tk.pop_front());
            void'(q_tag.pop_front());
        end
    end

    // Driver: one cycle of stimulus, model update, expectation push
    task automatic step(input logic v, input logic [W-1:0] idx, input logic tk, input string tag);
        @(negedge clk);
        upd_valid = v;
        upd_idx   = idx;
        upd_taken = tk;
        #1;
        if (v && idx == m_ghr) begin
            // R8: guess in the write cycle shows the old counter
            checks++;
            if (pred_taken !== m_ctr[idx][1]) begin
                fails++;
                $display("FAIL R8 same-cycle taken act=%0b exp=%0b", pred_taken, m_ctr[idx][1]);
            end
        end
        if (v) begin
            m_ctr[idx] = m_step(m_ctr[idx], tk);
            m_ghr      = {m_ghr[W-2:0], tk};
        end
        q_due.push_back(cyc + 1);
        q_idx.push_back(m_ghr);
        q_tk.push_back(m_ctr[m_ghr][1]);
        q_tag.push_back(tag);
        @(posedge clk);
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) m_ctr[i] = 2'b10;
        m_ghr = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        checks++;
        if (pred_idx !== '0 || pred_taken !== 1'b1) begin
            fails++;
            $display("FAIL R1 reset idx act=%0h exp=0 taken act=%0b exp=1", pred_idx, pred_taken);
        end
        @(posedge clk);

        // R6: strobe low with noise on the other update inputs
        step(1'b0, 4'h0, 1'b0, "R6");
        step(1'b0, 4'h7, 1'b1, "R6");
        step(1'b0, 4'hF, 1'b0, "R6");

        // R5: T, NT, T, T gives 0001, 0010, 0101, 1011
        step(1'b1, 4'h8, 1'b1, "R5");
        step(1'b1, 4'h8, 1'b0, "R5");
        step(1'b1, 4'h8, 1'b1, "R5");
        step(1'b1, 4'h8, 1'b1, "R5");

        // R3: push entry 15 past the top; history becomes 1111
        for (int k = 0; k < 5; k++) step(1'b1, 4'hF, 1'b1, "R3");
        // R8: write current entry 15 not-taken; old value 11 shows first
        step(1'b1, 4'hF, 1'b0, "R8");

        // R4: drive entry 0 below the bottom, then steer history back to 0000
        for (int k = 0; k < 4; k++) step(1'b1, 4'h0, 1'b0, "R4");
        step(1'b1, 4'h0, 1'b1, "R4");
        for (int k = 0; k < 4; k++) step(1'b1, 4'h9, 1'b0, "R4");

        // R7: train entry 3 while history points elsewhere, then steer to 0011
        step(1'b1, 4'h3, 1'b0, "R7");
        step(1'b1, 4'h3, 1'b0, "R7");
        step(1'b1, 4'h3, 1'b0, "R7");
        step(1'b1, 4'hA, 1'b1, "R7");
        step(1'b1, 4'hA, 1'b1, "R7");

        // R9: neighbours of a trained entry keep their reset value
        step(1'b1, 4'h6, 1'b0, "R9");
        step(1'b1, 4'h6, 1'b0, "R9");
        step(1'b1, 4'hC, 1'b1, "R9");
        step(1'b1, 4'hC, 1'b1, "R9");
        step(1'b1, 4'hC, 1'b1, "R9");

        // R2: random traffic, often aimed at the current entry
        for (int k = 0; k < 400; k++) begin
            logic         v;
            logic [W-1:0] ix;
            v  = ($urandom % 4) != 0;
            ix = ($urandom % 2 == 0) ? m_ghr : W'($urandom);
            step(v, ix, 1'($urandom), "R2");
        end

        step(1'b0, 4'h0, 1'b0, "R6");
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule